// File: doc/BRIEF.md
# Prioritised Address Window Chip-Select Decoder

This block sits beside an external bus controller and decides, for each bus cycle, which of four programmable address windows the cycle falls in. Each window has an enable, a base address and a size exponent; the size is a power of two and the base is taken as aligned to it. Where windows overlap, a fixed priority picks the winner. An address that no enabled window claims goes to the default region. The decoder reports the chosen configuration index to the bus timing logic and drives five active-low chip selects: one for each window and one for the default region.

The decision is captured on the clock edge that first sees the address-latch strobe high during a valid cycle. It holds until the cycle-valid strobe drops, and then every chip select goes inactive. A timing bit picks when the chip selects move. With the bit set, they move on that capturing clock edge. With the bit clear, they move half a clock later, on the following falling edge. The bus timing itself is not part of this block.

Top module: `addr_window_decoder`

## Requirements
- R1: Window k (1..4) matches when its enable bit `win_en[k-1]` is 1 and the address bits at positions `win_size` and above equal the same bits of its base. The base bits below the size are ignored. A size of AW or more matches every address. Window k uses `win_base[(k-1)*AW +: AW]` and `win_size[(k-1)*SW +: SW]`.
- R2: Matching windows are ranked 4 over 3 over 2 over 1. The 4/3 pair outranks the 2/1 pair, and within each pair the higher-numbered window wins.
- R3: When no enabled window matches, configuration 0 is selected and `cs_n[0]` is asserted.
- R4: `cfg_sel` reports the selected window number (1..4) or 0 for the default region, and the asserted chip select is `cs_n[cfg_sel]`.
- R5: At most one bit of `cs_n` is low at any time.
- R6: When `cyc_valid` is low at a rising clock edge, all chip selects go high: at that edge in early mode, half a clock later in late mode. `cfg_sel` keeps its last value.
- R7: With `cs_early` = 1, `cs_n` and `cfg_sel` change on the rising clock edge that first samples `ale` high (after a low sample) while `cyc_valid` is high.
- R8: With `cs_early` = 0, `cs_n` changes on the falling clock edge that follows that capturing rising edge, while `cfg_sel` still changes on the rising edge.
- R9: An `ale` rise sampled while `cyc_valid` is low is ignored. So is `ale` held high without a new rise: chip selects stay inactive.
- R10: After reset `cs_n` is all ones and `cfg_sel` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; decisions on rising edge, late-mode output on falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | AW | Bus address of the current cycle |
| cyc_valid | input | 1 | High for the whole of a bus cycle |
| ale | input | 1 | Address-latch strobe, synchronous to `clk` |
| win_en | input | 4 | Enable bit per window, bit k-1 for window k |
| win_base | input | 4*AW | Window base addresses, window k in slice k-1 |
| win_size | input | 4*SW | Window size exponents (log2 of bytes), window k in slice k-1 |
| cs_early | input | 1 | 1: chip selects change on the capturing edge; 0: half a clock later |
| cfg_sel | output | 3 | Selected configuration: 0 default, 1..4 window number |
| cs_n | output | 5 | Active-low chip selects, bit 0 default region, bit k window k |

## Verification
With an 8-bit address, every address is swept through four window layouts, each in both timing modes. The first layout nests each window pair with an unaligned base, which separates the within-pair priority and shows that base bits below the size are ignored. An all-disabled layout shows the default-region fallback. Two layouts let the pairs overlap across each other: a whole-space window 1 under a small window 4, and window 3 inside window 2, next to a disabled whole-space window 4. These show the order between pairs and that the enable is obeyed. Each access is sampled before and after the falling edge and again after the cycle ends, which tells the two timing modes apart. Extra strobe sequences check that a latch strobe outside a valid cycle, or one held high, does not assert anything.

// File: rtl/addr_window_decoder.sv
module addr_window_decoder #(
  parameter int AW = 24,
  localparam int SW = $clog2(AW + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   addr,
  input  logic            cyc_valid,
  input  logic            ale,
  input  logic [3:0]      win_en,
  input  logic [4*AW-1:0] win_base,
  input  logic [4*SW-1:0] win_size,
  input  logic            cs_early,
  output logic [2:0]      cfg_sel,
  output logic [4:0]      cs_n
);

  logic [3:0] hit;
  logic [2:0] sel_nx;
  logic [4:0] pick;
  logic       ale_d, cap;
  logic [4:0] cs_pos, cs_neg;

  for (genvar k = 0; k < 4; k++) begin : g_win
    logic [AW-1:0] mask;
    assign mask   = {AW{1'b1}} << win_size[k*SW +: SW];
    assign hit[k] = win_en[k] && (((addr ^ win_base[k*AW +: AW]) & mask) == '0);
  end

  always_comb begin
    if      (hit[3]) sel_nx = 3'd4;
    else if (hit[2]) sel_nx = 3'd3;
    else if (hit[1]) sel_nx = 3'd2;
    else if (hit[0]) sel_nx = 3'd1;
    else             sel_nx = 3'd0;
  end

  assign pick = 5'b00001 << sel_nx;
  assign cap  = cyc_valid && ale && !ale_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale_d   <= 1'b0;
      cs_pos  <= '1;
      cfg_sel <= '0;
    end else begin
      ale_d <= ale;
      if (!cyc_valid) cs_pos <= '1;
      else if (cap) begin
        cs_pos  <= ~pick;
        cfg_sel <= sel_nx;
      end
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) cs_neg <= '1;
    else        cs_neg <= cs_pos;
  end

  assign cs_n = cs_early ? cs_pos : cs_neg;

  p_single_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));
  p_default_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && hit == 4'b0000) |=> (cfg_sel == 3'd0 && cs_pos == 5'b11110));
  p_top_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && hit[3]) |=> cfg_sel == 3'd4);
  p_low_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && hit[1] && !hit[3] && !hit[2]) |=> cfg_sel == 3'd2);
  p_index_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> !cs_pos[cfg_sel]);
  p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_valid |=> &cs_pos);
  p_late_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_early |-> cs_n == cs_pos);

endmodule

// File: tb/tb_addr_window_decoder.sv
module tb_addr_window_decoder;
  localparam int AW = 8;
  localparam int SW = $clog2(AW + 1);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [AW-1:0]   addr = '0;
  logic            cyc_valid = 1'b0;
  logic            ale = 1'b0;
  logic [3:0]      win_en = '0;
  logic [4*AW-1:0] win_base = '0;
  logic [4*SW-1:0] win_size = '0;
  logic            cs_early = 1'b1;
  logic [2:0]      cfg_sel;
  logic [4:0]      cs_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  addr_window_decoder #(.AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .cyc_valid(cyc_valid), .ale(ale),
    .win_en(win_en), .win_base(win_base), .win_size(win_size),
    .cs_early(cs_early), .cfg_sel(cfg_sel), .cs_n(cs_n)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic set_win(input int k, input bit en, input int base, input int sz);
    win_en[k-1] = en;
    win_base[(k-1)*AW +: AW] = base[AW-1:0];
    win_size[(k-1)*SW +: SW] = sz[SW-1:0];
  endtask

  function automatic int exp_sel(input int a);
    for (int w = 4; w >= 1; w--) begin
      int b = int'(win_base[(w-1)*AW +: AW]);
      int s = int'(win_size[(w-1)*SW +: SW]);
      if (win_en[w-1] && (s >= AW || (a >> s) == (b >> s))) return w;
    end
    return 0;
  endfunction

  task automatic access(input int a);
    int s = exp_sel(a);
    int cs = 5'h1f & ~(1 << s);
    @(posedge clk); #1;
    addr = a[AW-1:0]; cyc_valid = 1'b1; ale = 1'b1;
    @(posedge clk); #2;
    if (cs_early) begin
      check("R1/R2/R3 cs_n early", int'(cs_n), cs);
      check("R4/R7 cfg_sel", int'(cfg_sel), s);
    end else begin
      check("R8 cs_n before falling edge", int'(cs_n), 5'h1f);
      check("R4/R8 cfg_sel", int'(cfg_sel), s);
    end
    #4;
    check("R1/R2/R3 cs_n after falling edge", int'(cs_n), cs);
    @(posedge clk); #1;
    ale = 1'b0; cyc_valid = 1'b0;
    @(posedge clk); #2;
    check("R6 cs_n at cycle end", int'(cs_n), cs_early ? 5'h1f : cs);
    #4;
    check("R6 cs_n idle", int'(cs_n), 5'h1f);
  endtask

  task automatic layout(input int n);
    case (n)
      0: begin
        set_win(4, 1, 'h4F, 4); set_win(3, 1, 'h40, 6);
        set_win(2, 1, 'h80, 5); set_win(1, 1, 'h80, 7);
      end
      1: begin
        set_win(4, 0, 'h00, 8); set_win(3, 0, 'h40, 6);
        set_win(2, 0, 'h80, 5); set_win(1, 0, 'h00, 8);
      end
      2: begin
        set_win(4, 1, 'h10, 3); set_win(3, 0, 'h00, 8);
        set_win(2, 0, 'h00, 8); set_win(1, 1, 'h00, 8);
      end
      default: begin
        set_win(4, 0, 'h00, 8); set_win(3, 1, 'h20, 5);
        set_win(2, 1, 'h00, 7); set_win(1, 1, 'hC0, 6);
      end
    endcase
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #20;
    check("R10 reset cs_n", int'(cs_n), 5'h1f);
    check("R10 reset cfg_sel", int'(cfg_sel), 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #2;
    check("R10 cs_n after release", int'(cs_n), 5'h1f);

    for (int n = 0; n < 4; n++) begin
      layout(n);
      for (int m = 0; m < 2; m++) begin
        cs_early = (m == 0);
        for (int a = 0; a < 256; a++) access(a);
      end
    end

    // R9: strobe outside a valid cycle, then strobe held high with no new rise
    layout(1);
    cs_early = 1'b1;
    @(posedge clk); #1;
    addr = 8'h33; cyc_valid = 1'b0; ale = 1'b1;
    @(posedge clk); #2;
    check("R9 rise while invalid", int'(cs_n), 5'h1f);
    #6; cyc_valid = 1'b1;
    @(posedge clk); #2;
    check("R9 ale held high", int'(cs_n), 5'h1f);
    @(posedge clk); #2;
    check("R9 ale held high later", int'(cs_n), 5'h1f);
    #6; ale = 1'b0; cyc_valid = 1'b0;
    @(posedge clk); @(posedge clk);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule